// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block takes 32-bit ARINC 429 words from a 16-bit host bus and sends them on a pair of complementary return-to-zero logic lines. The host writes each word as two halves. The first strobe latches the low half. The second strobe supplies the high half and pushes the whole word into an eight-entry queue.

When transmission is enabled and the queue holds a word, the serializer removes the word and sends it least significant bit first. The bit period is the master clock divided by 10 (fast) or by 80 (slow). Each bit pulses one line for half a period and leaves both lines low for the other half. A null gap of four bit periods follows every word. Odd parity can replace the top bit. A ready flag shows that the queue is empty and no word is being sent. Strobes that arrive while the queue is full are dropped and reported with a one-cycle overflow pulse.

Top module: `a429_word_tx`

## Requirements
- R1: The queue holds 8 words. With the queue full and transmission held off, a further commit is dropped, and only the 8 stored words are sent, in the order they were written.
- R2: A strobe on `load_lo_i` latches `bus_i` as word bits [15:0]. A strobe on `load_hi_i` takes `bus_i` as bits [31:16] and commits the word to the queue.
- R3: The bit period is 10 clocks when `slow_i`=0 and 80 clocks when `slow_i`=1. The rate is sampled when a word starts and held until that word's gap has ended.
- R4: A bit of value 1 drives `line_one_o` high for the first half of its period. A bit of value 0 drives `line_zero_o` high for that half. Both lines are low for the second half, and the two lines are never high together.
- R5: Word bit [0] goes out first and bit [31] goes out last.
- R6: A word starts only when `tx_en_i`=1 and the queue is non-empty. `tx_en_i` is checked only between words, so clearing it during a word lets that word finish and stops the next one.
- R7: When words follow back to back, the first pulse of a word starts exactly 5 bit periods plus 1 clock after the first pulse of the previous word's last bit. That is one bit period, then four null bit periods, then one idle clock.
- R8: When `par_en_i`=1 at the start of a word, bit [31] is sent as the value that gives the 32 sent bits odd parity.
- R9: `ready_o` is 1 when the queue is empty and no data bit is being sent. It drops in the clock after a commit into an empty queue, and it returns after bit 32 of the last word.
- R10: While the queue is full, both load strobes are ignored, including the low-half latch. `ovf_o` pulses high for one clock in the cycle after each ignored strobe.
- R11: After reset both lines are low, `ready_o`=1 and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_i | input | 16 | Host data half-word |
| load_lo_i | input | 1 | Latch low half (one-clock strobe) |
| load_hi_i | input | 1 | Take high half and commit word (one-clock strobe) |
| tx_en_i | input | 1 | Permit word transmission |
| slow_i | input | 1 | Rate select: 0 = clock/10, 1 = clock/80 |
| par_en_i | input | 1 | Replace bit 32 with odd parity |
| line_one_o | output | 1 | Return-to-zero drive for ones |
| line_zero_o | output | 1 | Return-to-zero drive for zeros |
| ready_o | output | 1 | Queue empty and serializer not sending |
| ovf_o | output | 1 | Pulse: strobe dropped on a full queue |

## Verification
The bench uses the default parameters: dividers of 10 and 80, a queue depth of 8 and a four-bit gap. With these values a slow word lasts 2560 clocks and still fits the run, so both rates can be measured pulse by pulse. Eight commits fill the queue, which makes the overflow path, the dropped low-half latch and the full drain reachable in a short run. The exact back-to-back gap of 51 clocks at the fast rate is also within reach.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SEND = 2'd1,
    S_GAP  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tx_word_fifo.sv
module tx_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (count_q == CW'(DEPTH));
  assign empty_o   = (count_q == '0);
  assign rd_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_en_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({wr_en_i, rd_en_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (count_q < CW'(DEPTH)));
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (count_q != '0));
  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic slow_i,
  output logic bit_end_o,
  output logic first_half_o
);
  localparam int CNT_W = $clog2(DIV_SLOW);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(DIV_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(DIV_SLOW - 1);
  localparam logic [CNT_W-1:0] HALF_F = CNT_W'(DIV_FAST / 2);
  localparam logic [CNT_W-1:0] HALF_S = CNT_W'(DIV_SLOW / 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last         = slow_i ? LAST_S : LAST_F;
  assign bit_end_o    = run_i && (cnt_q == last);
  assign first_half_o = cnt_q < (slow_i ? HALF_S : HALF_F);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || bit_end_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bit_end_o) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int GAP_BITS  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tx_en_i,
  input  logic                 slow_i,
  input  logic                 par_en_i,
  input  logic                 have_word_i,
  input  logic [WORD_BITS-1:0] word_i,
  input  logic                 bit_end_i,
  input  logic                 first_half_i,
  output logic                 pop_o,
  output logic                 run_o,
  output logic                 slow_q_o,
  output logic                 busy_o,
  output logic                 line_one_o,
  output logic                 line_zero_o
);
  localparam int BIT_W = $clog2(WORD_BITS);
  localparam int GAP_W = $clog2(GAP_BITS + 1);

  tx_state_e              state_q;
  logic [WORD_BITS-1:0]   shift_q;
  logic [BIT_W-1:0]       bit_idx_q;
  logic [GAP_W-1:0]       gap_idx_q;
  logic                   slow_q;
  logic [WORD_BITS-1:0]   load_word;

  // bit 32 forced so the whole word has odd parity
  assign load_word = par_en_i
                   ? {~^word_i[WORD_BITS-2:0], word_i[WORD_BITS-2:0]}
                   : word_i;

  assign pop_o       = (state_q == S_IDLE) && tx_en_i && have_word_i;
  assign run_o       = (state_q != S_IDLE);
  assign busy_o      = (state_q == S_SEND);
  assign slow_q_o    = slow_q;
  assign line_one_o  = busy_o && first_half_i && shift_q[0];
  assign line_zero_o = busy_o && first_half_i && !shift_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      shift_q   <= '0;
      bit_idx_q <= '0;
      gap_idx_q <= '0;
      slow_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (pop_o) begin
            shift_q   <= load_word;
            slow_q    <= slow_i;
            bit_idx_q <= '0;
            state_q   <= S_SEND;
          end
        end
        S_SEND: begin
          if (bit_end_i) begin
            shift_q <= shift_q >> 1;
            if (bit_idx_q == BIT_W'(WORD_BITS - 1)) begin
              gap_idx_q <= '0;
              state_q   <= S_GAP;
            end else begin
              bit_idx_q <= bit_idx_q + 1'b1;
            end
          end
        end
        S_GAP: begin
          if (bit_end_i) begin
            if (gap_idx_q == GAP_W'(GAP_BITS - 1)) state_q <= S_IDLE;
            else gap_idx_q <= gap_idx_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_rate_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> $stable(slow_q));
  p_shift_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SEND && !bit_end_i) |=> $stable(shift_q));
  p_gap_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_GAP) |-> !(line_one_o || line_zero_o));
endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
  import a429_tx_pkg::*;
#(
  parameter int DIV_FAST   = 10,
  parameter int DIV_SLOW   = 80,
  parameter int FIFO_DEPTH = 8,
  parameter int GAP_BITS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] bus_i,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic              tx_en_i,
  input  logic              slow_i,
  input  logic              par_en_i,
  output logic              line_one_o,
  output logic              line_zero_o,
  output logic              ready_o,
  output logic              ovf_o
);
  logic [HALF_W-1:0] lo_q;
  logic              ovf_q;
  logic              full, empty, push, pop;
  logic [WORD_W-1:0] head_word;
  logic              run, slow_q, busy, bit_end, first_half;

  assign push    = load_hi_i && !full;
  assign ready_o = empty && !busy;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (load_lo_i && !full) lo_q <= bus_i;
      ovf_q <= (load_lo_i || load_hi_i) && full;
    end
  end

  tx_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (push),
    .wr_data_i ({bus_i, lo_q}),
    .rd_en_i   (pop),
    .rd_data_o (head_word),
    .full_o    (full),
    .empty_o   (empty)
  );

  tx_bit_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .slow_i       (slow_q),
    .bit_end_o    (bit_end),
    .first_half_o (first_half)
  );

  tx_serializer #(.WORD_BITS(WORD_W), .GAP_BITS(GAP_BITS)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_en_i      (tx_en_i),
    .slow_i       (slow_i),
    .par_en_i     (par_en_i),
    .have_word_i  (!empty),
    .word_i       (head_word),
    .bit_end_i    (bit_end),
    .first_half_i (first_half),
    .pop_o        (pop),
    .run_o        (run),
    .slow_q_o     (slow_q),
    .busy_o       (busy),
    .line_one_o   (line_one_o),
    .line_zero_o  (line_zero_o)
  );

  p_lines_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_one_o && line_zero_o));
  p_ready_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !(line_one_o || line_zero_o));
  p_ovf_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(full));
endmodule

// File: tb/sim_a429_word_tx.sv
`timescale 1ns/1ps
module sim_a429_word_tx;
  localparam int NP = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus_i = '0;
  logic        load_lo_i = 1'b0, load_hi_i = 1'b0;
  logic        tx_en_i = 1'b0, slow_i = 1'b0, par_en_i = 1'b0;
  logic        line_one_o, line_zero_o, ready_o, ovf_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // pulse monitor
  int  pc = 0, p_w = 0;
  bit  in_p = 0, both_seen = 0;
  int  p_start [NP];
  int  p_width [NP];
  bit  p_val   [NP];

  // {slow, par, word}
  localparam logic [33:0] VEC [4] = '{
    {1'b0, 1'b0, 32'hA5C3_0F81},
    {1'b1, 1'b0, 32'h8000_0001},
    {1'b0, 1'b1, 32'h0000_0003},
    {1'b1, 1'b1, 32'hF0F0_1234}
  };

  always #2 clk_i = ~clk_i;

  a429_word_tx u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_i(bus_i),
    .load_lo_i(load_lo_i), .load_hi_i(load_hi_i),
    .tx_en_i(tx_en_i), .slow_i(slow_i), .par_en_i(par_en_i),
    .line_one_o(line_one_o), .line_zero_o(line_zero_o),
    .ready_o(ready_o), .ovf_o(ovf_o)
  );

  always @(negedge clk_i) begin
    cyc++;
    if (line_one_o && line_zero_o) both_seen = 1;
    if ((line_one_o || line_zero_o) && !in_p) begin
      in_p = 1; p_w = 1;
      if (pc < NP) begin p_start[pc] = cyc; p_val[pc] = line_one_o; end
    end else if ((line_one_o || line_zero_o) && in_p) begin
      p_w++;
    end else if (in_p) begin
      in_p = 0;
      if (pc < NP) p_width[pc] = p_w;
      pc++;
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog: run hung at cycle %0d (act running, exp finished)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic strobe_lo(input logic [15:0] v, output bit ov);
    @(negedge clk_i); bus_i = v; load_lo_i = 1'b1;
    @(negedge clk_i); ov = ovf_o; load_lo_i = 1'b0;
  endtask

  task automatic strobe_hi(input logic [15:0] v, output bit ov);
    @(negedge clk_i); bus_i = v; load_hi_i = 1'b1;
    @(negedge clk_i); ov = ovf_o; load_hi_i = 1'b0;
  endtask

  task automatic commit(input logic [31:0] w, output bit ov);
    bit a, b;
    strobe_lo(w[15:0], a);
    strobe_hi(w[31:16], b);
    ov = a | b;
  endtask

  task automatic wait_pulses(input int target, input string req);
    int n = 0;
    while (pc < target && n < 20000) begin @(negedge clk_i); n++; end
    check(pc >= target, req, pc, target);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready_o && n < 20000) begin @(negedge clk_i); n++; end
    check(ready_o, req, ready_o, 1);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic logic [31:0] get_word(input int base);
    logic [31:0] w;
    for (int k = 0; k < 32; k++) w[k] = p_val[base + k];
    return w;
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] w, input bit par);
    return par ? {~^w[30:0], w[30:0]} : w;
  endfunction

  initial begin
    int base, div, bad_w, bad_i;
    bit ov;
    logic [31:0] w;

    wait_cycles(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check(!line_one_o && !line_zero_o, "R11 lines low", {line_one_o, line_zero_o}, 0);
    check(ready_o, "R11 ready", ready_o, 1);
    check(!ovf_o, "R11 ovf", ovf_o, 0);

    // vector walk: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < 4; i++) begin
      slow_i = VEC[i][33]; par_en_i = VEC[i][32]; w = VEC[i][31:0];
      div = slow_i ? 80 : 10;
      tx_en_i = 1'b0;
      commit(w, ov);
      check(!ready_o, "R9 ready drops after commit", ready_o, 0);
      base = pc;
      tx_en_i = 1'b1;
      wait_pulses(base + 32, "R6 word sent");
      tx_en_i = 1'b0;
      check(get_word(base) == expect_word(w, par_en_i), par_en_i ? "R8 parity word" : "R5 R2 bit order",
            get_word(base), expect_word(w, par_en_i));
      bad_w = 0; bad_i = 0;
      for (int k = 0; k < 32; k++) if (p_width[base + k] != div / 2) bad_w++;
      for (int k = 0; k < 31; k++)
        if (p_start[base + k + 1] - p_start[base + k] != div) bad_i++;
      check(bad_w == 0, "R4 half-period pulses", p_width[base], div / 2);
      check(bad_i == 0, "R3 bit period", p_start[base + 1] - p_start[base], div);
      wait_ready("R9 ready after last bit");
    end
    check(!both_seen, "R4 lines exclusive", both_seen, 0);

    // R6: hold off, then clear enable mid-word
    slow_i = 1'b0; par_en_i = 1'b0; tx_en_i = 1'b0;
    commit(32'h1357_9BDF, ov);
    commit(32'h2468_ACE0, ov);
    base = pc;
    wait_cycles(300);
    check(pc == base, "R6 no send while disabled", pc - base, 0);
    check(!ready_o, "R9 not ready with queued words", ready_o, 0);
    tx_en_i = 1'b1;
    wait_pulses(base + 5, "R6 start");
    tx_en_i = 1'b0;
    wait_cycles(800);
    check(pc == base + 32, "R6 word in flight completes only", pc - base, 32);
    check(get_word(base) == 32'h1357_9BDF, "R6 first word", get_word(base), 32'h1357_9BDF);
    tx_en_i = 1'b1;
    wait_pulses(base + 64, "R6 resume");
    check(get_word(base + 32) == 32'h2468_ACE0, "R6 second word", get_word(base + 32), 32'h2468_ACE0);
    tx_en_i = 1'b0;
    wait_ready("R9 ready");

    // R7: back-to-back gap
    commit(32'h0F0F_0F0F, ov);
    commit(32'hFFFF_0000, ov);
    base = pc;
    tx_en_i = 1'b1;
    wait_pulses(base + 64, "R7 two words");
    tx_en_i = 1'b0;
    check(p_start[base + 32] - p_start[base + 31] == 51, "R7 null gap",
          p_start[base + 32] - p_start[base + 31], 51);
    check(get_word(base + 32) == 32'hFFFF_0000, "R7 second word", get_word(base + 32), 32'hFFFF_0000);
    wait_ready("R9 ready");

    // R1 R10: fill, overflow, drain
    for (int k = 0; k < 8; k++) begin
      commit({16'hC000 | 16'(k), 16'h0300 | 16'(k)}, ov);
      check(!ov, "R1 no overflow below depth", ov, 0);
    end
    strobe_lo(16'hDEAD, ov);
    check(ov, "R10 ovf on low strobe when full", ov, 1);
    strobe_hi(16'hBEEF, ov);
    check(ov, "R10 ovf on high strobe when full", ov, 1);
    @(negedge clk_i);
    check(!ovf_o, "R10 ovf single pulse", ovf_o, 0);
    base = pc;
    tx_en_i = 1'b1;
    wait_pulses(base + 256, "R1 eight words");
    check(get_word(base) == 32'hC000_0300, "R1 first stored word", get_word(base), 32'hC000_0300);
    check(get_word(base + 224) == 32'hC007_0307, "R1 eighth stored word",
          get_word(base + 224), 32'hC007_0307);
    wait_cycles(1000);
    check(pc == base + 256, "R1 ninth word dropped", pc - base, 256);
    check(ready_o, "R9 ready after drain", ready_o, 1);
    tx_en_i = 1'b0;
    strobe_hi(16'h5A5A, ov);
    base = pc;
    tx_en_i = 1'b1;
    wait_pulses(base + 32, "R10 send");
    check(get_word(base) == 32'h5A5A_0307, "R10 low half kept while full",
          get_word(base), 32'h5A5A_0307);
    tx_en_i = 1'b0;
    wait_ready("R9 ready");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule